// File: doc/BRIEF.md
# Interlocked Glitch-Free Base Clock Selector

The block picks the base clock of a system from one of two free-running inputs: an oscillator clock and a clock that a PLL produces. A handover circuit changes the source without producing short pulses. While the handover runs, no source drives the output, so the output does not move. The selected clock then passes through a divide-by-two stage, which gives a 50% duty cycle. The base clock therefore runs at half the selected frequency, and a bus clock derived from it runs at a quarter. A configuration bit can skip the divider, but only while the oscillator is the source.

A small write port in the system clock domain holds the PLL select bit, the PLL enable bit, the divider bypass bit and three PLL loop factors: a reference divider, a multiplier and a lock-range factor. Every write loads all fields together. The control bits are interlocked, so an illegal combination of enable and select never reaches the register. The stored values can be read back at all times. A zero reference divider or multiplier reads back and drives out as one. A zero lock-range factor turns the PLL off and forces the oscillator source. The analog PLL and the oscillator are outside the block: their clocks arrive as primary inputs.

Top module: `bclk_selector`

## Requirements
- R1: After reset, the select, enable and bypass bits read 0, the reference divider and multiplier read 1, and the lock-range factor reads 1. The oscillator chain becomes active, the PLL chain stays inactive, and the base clock period is twice the oscillator period.
- R2: A write that sets the select bit while the stored enable bit is 0 leaves the select bit at 0.
- R3: A write that clears the enable bit while the stored select bit is 1 leaves the enable bit at 1.
- R4: A write that requests a change to both the enable bit and the select bit applies only the enable change, and only if R3 allows it. The select bit keeps its old value.
- R5: The PLL run output equals enable AND (lock-range factor not 0). While the lock-range factor is 0, the oscillator is the source, whatever the select bit holds.
- R6: A reference divider or multiplier written as 0 reads back as 1. Any other written value reads back unchanged.
- R7: The oscillator chain and the PLL chain are never both active. After the source request changes, the handover completes within 80 ns at the bench clock rates (oscillator 10 ns, PLL 6 ns). No base clock pulse is narrower than half a period of the faster source.
- R8: With the bypass bit at 0, the base clock period is twice the period of the active source.
- R9: With the bypass bit at 1 and the oscillator active, the base clock period equals the oscillator period.
- R10: With the PLL active, the bypass bit has no effect: the base clock period stays at twice the PLL period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the write port and control registers |
| rst | input | 1 | Synchronous active-high reset |
| osc_clk | input | 1 | Oscillator clock source |
| pll_clk | input | 1 | PLL clock source |
| wr_en | input | 1 | Write strobe; loads all fields below |
| wr_sel | input | 1 | Requested select bit (1 = PLL source, 0 = oscillator) |
| wr_pll_en | input | 1 | Requested PLL enable bit |
| wr_bypass | input | 1 | Requested divider bypass bit for the oscillator path |
| wr_r | input | R_W | Requested reference divider |
| wr_n | input | N_W | Requested multiplier |
| wr_l | input | L_W | Requested lock-range factor |
| sel_q | output | 1 | Stored select bit |
| pll_en_q | output | 1 | Stored PLL enable bit |
| bypass_q | output | 1 | Stored bypass bit |
| r_eff | output | R_W | Effective reference divider (never 0) |
| n_eff | output | N_W | Effective multiplier (never 0) |
| l_q | output | L_W | Stored lock-range factor |
| pll_run | output | 1 | Enable to the analog PLL |
| osc_active | output | 1 | Oscillator chain drives the output |
| pll_active | output | 1 | PLL chain drives the output |
| base_clk | output | 1 | Base clock output |

## Verification
The assertions check three things on every cycle: the select bit never rises without the enable bit, the enable bit never falls while select is set, and the two bits never change in the same cycle. They also check that the two source chains are never active together and that a zero factor written in always lands as one. The bench scenarios cover what only time and frequency can show: the base clock period for each source and bypass setting, the handover time, and the narrowest output pulse across a switch. The same applies to the forced fall-back to the oscillator when the lock-range factor is zero, and to the randomised write sequences checked against a separate model of the interlock.

// File: rtl/bclk_pkg.sv
package bclk_pkg;

    typedef struct packed {
        logic pll_sel;
        logic pll_en;
    } bclk_ctl_t;

    // Interlock: decide which requested control changes may be stored.
    function automatic bclk_ctl_t bclk_interlock(bclk_ctl_t cur, bclk_ctl_t req);
        bclk_ctl_t nxt;
        logic      en_move;
        logic      sel_move;
        nxt      = cur;
        en_move  = (req.pll_en != cur.pll_en);
        sel_move = (req.pll_sel != cur.pll_sel);
        // Enable may not drop while the PLL source is selected.
        if (en_move && !(cur.pll_sel && !req.pll_en))
            nxt.pll_en = req.pll_en;
        // Select moves only alone, and may not rise without enable.
        if (sel_move && !en_move && !(req.pll_sel && !cur.pll_en))
            nxt.pll_sel = req.pll_sel;
        return nxt;
    endfunction

endpackage

// File: rtl/bclk_regs.sv
module bclk_regs
    import bclk_pkg::*;
#(
    parameter int R_W = 4,
    parameter int N_W = 8,
    parameter int L_W = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic           wr_sel,
    input  logic           wr_pll_en,
    input  logic           wr_bypass,
    input  logic [R_W-1:0] wr_r,
    input  logic [N_W-1:0] wr_n,
    input  logic [L_W-1:0] wr_l,
    output bclk_ctl_t      ctl_q,
    output logic           bypass_q,
    output logic [R_W-1:0] r_eff,
    output logic [N_W-1:0] n_eff,
    output logic [L_W-1:0] l_q,
    output logic           pll_run,
    output logic           use_pll
);

    localparam logic [R_W-1:0] R_ONE = {{(R_W-1){1'b0}}, 1'b1};
    localparam logic [N_W-1:0] N_ONE = {{(N_W-1){1'b0}}, 1'b1};
    localparam logic [L_W-1:0] L_ONE = {{(L_W-1){1'b0}}, 1'b1};

    bclk_ctl_t req_ctl;
    bclk_ctl_t nxt_ctl;
    logic      l_nonzero;

    always_comb begin
        req_ctl.pll_sel = wr_sel;
        req_ctl.pll_en  = wr_pll_en;
        nxt_ctl         = bclk_interlock(ctl_q, req_ctl);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q    <= '0;
            bypass_q <= 1'b0;
            r_eff    <= R_ONE;
            n_eff    <= N_ONE;
            l_q      <= L_ONE;
        end else if (wr_en) begin
            ctl_q    <= nxt_ctl;
            bypass_q <= wr_bypass;
            r_eff    <= (wr_r == '0) ? R_ONE : wr_r;
            n_eff    <= (wr_n == '0) ? N_ONE : wr_n;
            l_q      <= wr_l;
        end
    end

    assign l_nonzero = (l_q != '0);
    assign pll_run   = ctl_q.pll_en & l_nonzero;
    assign use_pll   = ctl_q.pll_sel & pll_run;

    assert_sel_needs_en_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_q.pll_sel) |-> $past(ctl_q.pll_en));

    assert_en_held_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl_q.pll_en) |-> !$past(ctl_q.pll_sel));

    assert_single_move_R4: assert property (@(posedge clk) disable iff (rst)
        !(!$stable(ctl_q.pll_sel) && !$stable(ctl_q.pll_en)));

    assert_zero_factor_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_r == '0 && wr_n == '0) |=> (r_eff == R_ONE && n_eff == N_ONE));

endmodule

// File: rtl/bclk_switch.sv
module bclk_switch #(
    parameter int SYNC_DEPTH = 2
) (
    input  logic rst,
    input  logic osc_clk,
    input  logic pll_clk,
    input  logic req_pll,
    output logic osc_on,
    output logic pll_on,
    output logic mux_clk
);

    localparam int TOP = SYNC_DEPTH - 1;

    logic [TOP:0] osc_chain;
    logic [TOP:0] pll_chain;
    logic         osc_d;
    logic         pll_d;

    // Each chain starts only when the other chain is fully empty.
    assign osc_d = ~req_pll & ~(|pll_chain);
    assign pll_d =  req_pll & ~(|osc_chain);

    generate
        if (SYNC_DEPTH == 1) begin : g_one
            always_ff @(negedge osc_clk) osc_chain <= osc_d;
            always_ff @(negedge pll_clk) begin
                if (rst) pll_chain <= '0;
                else     pll_chain <= pll_d;
            end
        end else begin : g_many
            always_ff @(negedge osc_clk) osc_chain <= {osc_chain[TOP-1:0], osc_d};
            always_ff @(negedge pll_clk) begin
                if (rst) pll_chain <= '0;
                else     pll_chain <= {pll_chain[TOP-1:0], pll_d};
            end
        end
    endgenerate

    assign osc_on  = osc_chain[TOP];
    assign pll_on  = pll_chain[TOP];
    assign mux_clk = (osc_clk & osc_on) | (pll_clk & pll_on);

    always_comb begin
        assert_exclusive_R7: assert (!(osc_on && pll_on));
    end

endmodule

// File: rtl/bclk_div.sv
module bclk_div (
    input  logic rst,
    input  logic mux_clk,
    input  logic osc_on,
    input  logic bypass,
    output logic base_clk
);

    logic half_q;

    always_ff @(posedge mux_clk) begin
        if (rst) half_q <= 1'b0;
        else     half_q <= ~half_q;
    end

    // Bypass only applies on the oscillator path.
    assign base_clk = (bypass & osc_on) ? mux_clk : half_q;

endmodule

// File: rtl/bclk_selector.sv
module bclk_selector
    import bclk_pkg::*;
#(
    parameter int R_W        = 4,
    parameter int N_W        = 8,
    parameter int L_W        = 4,
    parameter int SYNC_DEPTH = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           osc_clk,
    input  logic           pll_clk,
    input  logic           wr_en,
    input  logic           wr_sel,
    input  logic           wr_pll_en,
    input  logic           wr_bypass,
    input  logic [R_W-1:0] wr_r,
    input  logic [N_W-1:0] wr_n,
    input  logic [L_W-1:0] wr_l,
    output logic           sel_q,
    output logic           pll_en_q,
    output logic           bypass_q,
    output logic [R_W-1:0] r_eff,
    output logic [N_W-1:0] n_eff,
    output logic [L_W-1:0] l_q,
    output logic           pll_run,
    output logic           osc_active,
    output logic           pll_active,
    output logic           base_clk
);

    bclk_ctl_t ctl_q;
    logic      use_pll;
    logic      mux_clk;

    bclk_regs #(.R_W(R_W), .N_W(N_W), .L_W(L_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_pll_en (wr_pll_en),
        .wr_bypass (wr_bypass),
        .wr_r      (wr_r),
        .wr_n      (wr_n),
        .wr_l      (wr_l),
        .ctl_q     (ctl_q),
        .bypass_q  (bypass_q),
        .r_eff     (r_eff),
        .n_eff     (n_eff),
        .l_q       (l_q),
        .pll_run   (pll_run),
        .use_pll   (use_pll)
    );

    bclk_switch #(.SYNC_DEPTH(SYNC_DEPTH)) u_switch (
        .rst     (rst),
        .osc_clk (osc_clk),
        .pll_clk (pll_clk),
        .req_pll (use_pll),
        .osc_on  (osc_active),
        .pll_on  (pll_active),
        .mux_clk (mux_clk)
    );

    bclk_div u_div (
        .rst      (rst),
        .mux_clk  (mux_clk),
        .osc_on   (osc_active),
        .bypass   (bypass_q),
        .base_clk (base_clk)
    );

    assign sel_q    = ctl_q.pll_sel;
    assign pll_en_q = ctl_q.pll_en;

endmodule

// File: tb/bclk_selector_bench.sv
`timescale 1ns/1ps
module bclk_selector_bench;

    logic       clk = 1'b0;
    logic       osc_clk = 1'b0;
    logic       pll_clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, wr_sel = 1'b0, wr_pll_en = 1'b0, wr_bypass = 1'b0;
    logic [3:0] wr_r = '0;
    logic [7:0] wr_n = '0;
    logic [3:0] wr_l = '0;
    logic       sel_q, pll_en_q, bypass_q, pll_run, osc_active, pll_active, base_clk;
    logic [3:0] r_eff;
    logic [7:0] n_eff;
    logic [3:0] l_q;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench mirror of the control state
    bit m_sel = 0, m_en = 0;

    realtime last_edge = 0.0;
    realtime min_w = 1000.0;

    always #2 clk = ~clk;
    always #5 osc_clk = ~osc_clk;
    always #3 pll_clk = ~pll_clk;

    bclk_selector u_bclk_selector (
        .clk(clk), .rst(rst), .osc_clk(osc_clk), .pll_clk(pll_clk),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_pll_en(wr_pll_en), .wr_bypass(wr_bypass),
        .wr_r(wr_r), .wr_n(wr_n), .wr_l(wr_l),
        .sel_q(sel_q), .pll_en_q(pll_en_q), .bypass_q(bypass_q),
        .r_eff(r_eff), .n_eff(n_eff), .l_q(l_q), .pll_run(pll_run),
        .osc_active(osc_active), .pll_active(pll_active), .base_clk(base_clk)
    );

    always @(base_clk) begin
        if ($realtime - last_edge < min_w) min_w = $realtime - last_edge;
        last_edge = $realtime;
    end

    function automatic bit [1:0] model_ctl(bit sel, bit en, bit wsel, bit wen);
        bit ns = sel;
        bit ne = en;
        bit ec = (wen != en);
        bit sc = (wsel != sel);
        if (ec && !(sel && !wen)) ne = wen;
        if (sc && !ec && !(wsel && !en)) ns = wsel;
        return {ns, ne};
    endfunction

    function automatic int norm(int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(bit s, bit e, bit b, int r, int n, int l);
        bit [1:0] nx;
        @(negedge clk);
        wr_en = 1; wr_sel = s; wr_pll_en = e; wr_bypass = b;
        wr_r = 4'(r); wr_n = 8'(n); wr_l = 4'(l);
        @(negedge clk);
        wr_en = 0;
        nx = model_ctl(m_sel, m_en, s, e);
        m_sel = nx[1]; m_en = nx[0];
    endtask

    task automatic wait_src(string tag, bit want_pll);
        bit ok = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (pll_active == want_pll && osc_active == !want_pll) begin
                ok = 1;
                break;
            end
        end
        chk(tag, int'(ok), 1);
    endtask

    task automatic period(string tag, int exp_ns);
        realtime t0;
        realtime t1;
        #200;
        @(posedge base_clk); t0 = $realtime;
        @(posedge base_clk); t1 = $realtime;
        chk(tag, $rtoi(t1 - t0 + 0.5), exp_ns);
    endtask

    task automatic pulse_chk(string tag);
        chk(tag, int'(min_w >= 2.9), 1);
    endtask

    initial begin
        #800000;
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (20) @(negedge clk);
        rst = 0;
        repeat (10) @(negedge clk);
        // R1 reset state
        chk("R1 sel", int'(sel_q), 0);
        chk("R1 en", int'(pll_en_q), 0);
        chk("R1 bypass", int'(bypass_q), 0);
        chk("R1 r", int'(r_eff), 1);
        chk("R1 n", int'(n_eff), 1);
        chk("R1 l", int'(l_q), 1);
        chk("R1 osc_active", int'(osc_active), 1);
        chk("R1 pll_active", int'(pll_active), 0);
        period("R1 period", 20);

        // R2 select without enable ignored
        wr(1, 0, 0, 1, 1, 1);
        chk("R2 sel", int'(sel_q), 0);
        #100;
        chk("R2 osc stays", int'(osc_active), 1);

        // R4 both change: only enable applied
        wr(1, 1, 0, 1, 1, 1);
        chk("R4 en", int'(pll_en_q), 1);
        chk("R4 sel", int'(sel_q), 0);
        chk("R5 pll_run", int'(pll_run), 1);

        // switch to PLL, check handover
        min_w = 1000.0;
        wr(1, 1, 0, 1, 1, 1);
        chk("R2 sel set with en", int'(sel_q), 1);
        wait_src("R7 handover to pll", 1);
        period("R8 pll period", 12);
        pulse_chk("R7 min pulse to pll");

        // R10 bypass no effect on PLL
        wr(1, 1, 1, 1, 1, 1);
        period("R10 bypass on pll", 12);
        chk("R10 pll still active", int'(pll_active), 1);

        // R3 enable clear while selected ignored
        wr(1, 0, 0, 1, 1, 1);
        chk("R3 en held", int'(pll_en_q), 1);
        chk("R3 sel held", int'(sel_q), 1);
        // R4 both clear requested: sel kept, en clear also rejected
        wr(0, 0, 0, 1, 1, 1);
        chk("R4 sel kept", int'(sel_q), 1);
        chk("R4 en kept", int'(pll_en_q), 1);

        // R5 zero lock-range factor forces oscillator
        min_w = 1000.0;
        wr(1, 1, 0, 1, 1, 0);
        chk("R5 pll_run zero l", int'(pll_run), 0);
        chk("R5 sel unchanged", int'(sel_q), 1);
        wait_src("R5 forced osc", 0);
        period("R5 osc period", 20);
        pulse_chk("R7 min pulse to osc");
        wr(1, 1, 0, 1, 1, 3);
        wait_src("R5 pll restored", 1);
        period("R8 pll again", 12);

        // back to oscillator, then bypass
        min_w = 1000.0;
        wr(0, 1, 0, 1, 1, 3);
        wait_src("R7 handover to osc", 0);
        period("R8 osc period", 20);
        pulse_chk("R7 min pulse back");
        wr(0, 1, 1, 1, 1, 3);
        period("R9 bypass osc", 10);

        // R6 zero factors
        wr(0, 1, 0, 0, 0, 3);
        chk("R6 r zero", int'(r_eff), 1);
        chk("R6 n zero", int'(n_eff), 1);
        wr(0, 1, 0, 5, 9, 3);
        chk("R6 r value", int'(r_eff), 5);
        chk("R6 n value", int'(n_eff), 9);

        // random write sequence against model
        for (int k = 0; k < 150; k++) begin
            bit rs = 1'($urandom);
            bit re = 1'($urandom);
            bit rb = 1'($urandom);
            int rr = ($urandom % 3 == 0) ? 0 : int'($urandom % 16);
            int rn = ($urandom % 3 == 0) ? 0 : int'($urandom % 256);
            int rl = ($urandom % 4 == 0) ? 0 : int'($urandom % 16);
            wr(rs, re, rb, rr, rn, rl);
            chk("R2 R3 R4 rand sel", int'(sel_q), int'(m_sel));
            chk("R2 R3 R4 rand en", int'(pll_en_q), int'(m_en));
            chk("R6 rand r", int'(r_eff), norm(rr));
            chk("R6 rand n", int'(n_eff), norm(rn));
            chk("R5 rand run", int'(pll_run), int'(m_en && rl != 0));
            repeat (28) @(negedge clk);
            chk("R7 rand source", int'(pll_active), int'(m_sel && m_en && rl != 0));
            chk("R7 rand excl", int'(osc_active ^ pll_active), 1);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule